// File: doc/BRIEF.md
# Sweep Sensor Frame Serializer

This block sends captured image frames from a sweep sensor to a host over a read-only SPI slave port. A frame starts with one fixed marker column and continues with `IMG_COLS` image columns (232 by default). Each column holds eight 4-bit pixels, so one column is 32 serial bits and a default frame is 4 × 8 × 233 = 7456 SCK pulses. Image columns come from a synchronous column memory through a read port. Each memory word holds one whole column, with pixel `p` in bits `[4p+3:4p]`.

The block runs on a fast system clock. It resynchronises SCK and the active-low select, then reacts to SCK falling edges. The SPI clock idles high. MISO takes a new bit after each SCK falling edge, and the host samples it on the rising edge. The stream runs only while `acq_en` is high and select is low; in every other state MISO is high impedance.

The first selection after a reset, or after acquisition mode is switched off and on again, begins with 40 warm-up bits. Later frames, and selections that restart the stream, begin directly with the marker column. A one-cycle `frame_start` pulse marks the first bit of each marker column.

Top module: `sweep_frame_serializer`

## Requirements
- R1: After reset, MISO is high impedance, `frame_start` is 0 and `rd_en` is 0.
- R2: MISO is high impedance while select is high or `acq_en` is low. SCK edges in either state have no effect on the stream.
- R3: On the first selection after reset, the first `WARM_CYCLES` (40) bits on MISO are 0 and precede the marker column.
- R4: Every frame starts with the marker column. Its nibbles, for pixel 0 to pixel 7, are F,0,F,0,0,2,0,0, which gives the bytes 0xF0,0xF0,0x02,0x00 in time order.
- R5: Each image column sends pixel 0 through pixel 7 in order, each as one nibble with its MSB first. Pixel 2k therefore forms the high nibble and pixel 2k+1 the low nibble of byte k. Image column j (j = 1..IMG_COLS) takes its pixels from memory word j-1.
- R6: When the last image column ends, the next bit is the first bit of the next frame's marker. Frames follow each other with no gap.
- R7: `frame_start` is a single system-clock pulse. It occurs together with the MISO update that presents the first marker bit of each frame.
- R8: If select goes high mid-frame, a new selection restarts at the first marker bit, with no warm-up.
- R9: Taking `acq_en` low makes the next selection run the warm-up again.
- R10: Exactly one read is made for each image column. The read addresses go 0,1,…,IMG_COLS-1 within a frame, and each read is made at least one column ahead of use. The memory answers `rd_data` on the clock after `rd_en`.
- R11: Marker starts are exactly (IMG_COLS+1)×32 bits apart, which is 7456 bits by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock, idles high |
| sel_n | input | 1 | Active-low slave select |
| acq_en | input | 1 | Acquisition mode enable |
| miso | output | 1 | Serial data, high impedance when inactive |
| rd_en | output | 1 | Column memory read strobe |
| rd_addr | output | $clog2(IMG_COLS) | Column memory word address |
| rd_data | input | 8×4 | Column word, pixel p at bits [4p+3:4p] |
| frame_start | output | 1 | One-cycle pulse at the first marker bit |

## Verification
The bench uses a small configuration with five image columns and compares every bit of several sessions against a stream model built arithmetically from the requirements.

It targets the following corner cases, and each shows up as follows if it is wrong:
- Warm-up: a design that skips the warm-up, or repeats it after a mid-frame deselect, shifts the whole stream by 40 bits.
- Frame wrap: a design that drops the marker at the wrap, or inserts a gap there, misplaces the second and third `frame_start` pulses.
- Pixel order: swapped nibbles or a wrong read address corrupt image bits.
- Re-arming: failing to re-arm the warm-up when `acq_en` drops puts the marker 40 bits too early.
- Idle states: SCK edges while deselected or outside acquisition mode must leave MISO floating and the stream unchanged.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // Marker column nibble for pixel position p (eight-pixel marker).
  function automatic logic [3:0] marker_nibble(input int unsigned p);
    case (p)
      0, 2:    marker_nibble = 4'hF;
      5:       marker_nibble = 4'h2;
      default: marker_nibble = 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int unsigned W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sfs_sequencer.sv
module sfs_sequencer
  import sfs_pkg::*;
#(
  parameter int unsigned IMG_COLS    = 232,
  parameter int unsigned PIX_PER_COL = 8,
  parameter int unsigned PIX_BITS    = 4,
  parameter int unsigned WARM_CYCLES = 40,
  localparam int unsigned COL_W   = PIX_PER_COL * PIX_BITS,
  localparam int unsigned CB_W    = $clog2(COL_W),
  localparam int unsigned CIDX_W  = $clog2(IMG_COLS + 1),
  localparam int unsigned ADDR_W  = $clog2(IMG_COLS),
  localparam int unsigned WCNT_W  = $clog2(WARM_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              acq_en,
  input  logic              step,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [COL_W-1:0]  rd_data,
  output logic              frame_start,
  output logic              emit_bit,
  output logic              warm_done
);
  localparam logic [CB_W-1:0]   LAST_CB  = CB_W'(COL_W - 1);
  localparam logic [CIDX_W-1:0] LAST_COL = CIDX_W'(IMG_COLS);
  localparam logic [WCNT_W-1:0] LAST_WRM = WCNT_W'(WARM_CYCLES - 1);

  // Marker column packed like a memory word: pixel p at [p*PIX_BITS +: PIX_BITS].
  function automatic logic [COL_W-1:0] marker_word();
    logic [COL_W-1:0] w;
    w = '0;
    for (int unsigned p = 0; p < PIX_PER_COL; p++) begin
      w[p*PIX_BITS +: PIX_BITS] = PIX_BITS'(marker_nibble(p));
    end
    return w;
  endfunction

  // Serial position cb within a column: pixel cb/PIX_BITS, MSB of the nibble first.
  function automatic logic col_bit(input logic [COL_W-1:0] w, input logic [CB_W-1:0] cb);
    int unsigned pix, pos;
    pix = int'(cb) / PIX_BITS;
    pos = (PIX_BITS - 1) - (int'(cb) % PIX_BITS);
    return w[pix*PIX_BITS + pos];
  endfunction

  localparam logic [COL_W-1:0] MARKER = marker_word();

  logic [CIDX_W-1:0] col;
  logic [CB_W-1:0]   cb;
  logic [WCNT_W-1:0] warm_cnt;
  logic [COL_W-1:0]  cur_word, next_buf, src_word;
  logic              rd_pend;

  always_comb begin
    if (col == '0)      src_word = MARKER;
    else if (cb == '0)  src_word = next_buf;
    else                src_word = cur_word;
    emit_bit = warm_done ? col_bit(src_word, cb) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col         <= '0;
      cb          <= '0;
      warm_cnt    <= '0;
      warm_done   <= 1'b0;
      cur_word    <= '0;
      next_buf    <= '0;
      rd_pend     <= 1'b0;
      rd_en       <= 1'b0;
      rd_addr     <= '0;
      frame_start <= 1'b0;
    end else begin
      rd_en       <= 1'b0;
      frame_start <= 1'b0;
      rd_pend     <= rd_en;
      if (rd_pend) next_buf <= rd_data;
      if (!acq_en) warm_done <= 1'b0;
      if (!active) begin
        col      <= '0;
        cb       <= '0;
        warm_cnt <= '0;
      end else if (step) begin
        if (!warm_done) begin
          if (warm_cnt == LAST_WRM) begin
            warm_done <= 1'b1;
            warm_cnt  <= '0;
          end else begin
            warm_cnt <= warm_cnt + 1'b1;
          end
        end else begin
          if (cb == '0) begin
            if (col != '0) cur_word <= next_buf;
            else           frame_start <= 1'b1;
            if (col != LAST_COL) begin
              rd_en   <= 1'b1;
              rd_addr <= ADDR_W'(col);
            end
          end
          if (cb == LAST_CB) begin
            cb  <= '0;
            col <= (col == LAST_COL) ? '0 : col + 1'b1;
          end else begin
            cb <= cb + 1'b1;
          end
        end
      end
    end
  end

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_rd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < ADDR_W'(IMG_COLS)));
  assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_idle_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cb == '0 && col == '0));
endmodule

// File: rtl/sfs_out.sv
module sfs_out (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic emit,
  input  logic emit_bit,
  output logic drive_bit,
  output logic miso
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drive_bit <= 1'b0;
    else if (!active) drive_bit <= 1'b0;
    else if (emit)    drive_bit <= emit_bit;
  end

  assign miso = active ? drive_bit : 1'bz;
endmodule

// File: rtl/sweep_frame_serializer.sv
module sweep_frame_serializer #(
  parameter int unsigned IMG_COLS    = 232,
  parameter int unsigned PIX_PER_COL = 8,
  parameter int unsigned PIX_BITS    = 4,
  parameter int unsigned WARM_CYCLES = 40,
  localparam int unsigned ADDR_W = $clog2(IMG_COLS),
  localparam int unsigned COL_W  = PIX_PER_COL * PIX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sel_n,
  input  logic              acq_en,
  output logic              miso,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [COL_W-1:0]  rd_data,
  output logic              frame_start
);
  logic [1:0] pins_s;
  logic       sck_d, sck_fall, active, step;
  logic       emit_bit, drive_bit, warm_done;

  sfs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, sel_n}), .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b1;
    else        sck_d <= pins_s[1];
  end

  assign sck_fall = sck_d & ~pins_s[1];
  assign active   = ~pins_s[0] & acq_en;
  assign step     = active & sck_fall;

  sfs_sequencer #(
    .IMG_COLS(IMG_COLS), .PIX_PER_COL(PIX_PER_COL),
    .PIX_BITS(PIX_BITS), .WARM_CYCLES(WARM_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .acq_en(acq_en), .step(step),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(frame_start), .emit_bit(emit_bit), .warm_done(warm_done)
  );

  sfs_out u_out (
    .clk(clk), .rst_n(rst_n), .active(active), .emit(step),
    .emit_bit(emit_bit), .drive_bit(drive_bit), .miso(miso)
  );

  // Marker begins with nibble F, so its first serial bit is 1.
  assert_marker_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> drive_bit);
  assert_warm_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !warm_done) |=> !drive_bit);
  assert_start_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> active);
endmodule

// File: tb/sim_sweep_frame_serializer.sv
module sim_sweep_frame_serializer;
  localparam int IMG = 5;
  localparam int PPC = 8;
  localparam int PB  = 4;
  localparam int WARM = 40;
  localparam int AW = $clog2(IMG);
  localparam int CW = PPC * PB;
  localparam int FBITS = (IMG + 1) * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1;
  logic sel_n = 1'b1;
  logic acq_en = 1'b0;
  wire  miso;
  logic rd_en, frame_start;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] rd_data = '0;

  int checks = 0, fails = 0;
  int sess_k = 0;
  int fs_cnt = 0, fs_last = -1;
  int rd_cnt = 0;

  always #5 clk = ~clk;

  sweep_frame_serializer #(.IMG_COLS(IMG)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sel_n(sel_n), .acq_en(acq_en),
    .miso(miso), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(frame_start)
  );

  function automatic int pix(int c, int p);
    return (c * 3 + p * 5 + 1) % 16;
  endfunction

  function automatic int mark(int p);
    int t[8] = '{15, 0, 15, 0, 0, 2, 0, 0};
    return t[p];
  endfunction

  // Column memory model: one-cycle synchronous read.
  always @(posedge clk) begin
    if (rd_en) begin
      for (int p = 0; p < PPC; p++) rd_data[p*PB +: PB] <= PB'(pix(int'(rd_addr), p));
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // R10: read addresses cycle 0..IMG-1.
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      check(int'(rd_addr) == rd_cnt % IMG, "R10 read address", int'(rd_addr), rd_cnt % IMG);
      rd_cnt++;
    end
    if (rst_n && frame_start) begin
      fs_cnt++;
      fs_last = sess_k;
    end
  end

  function automatic int exp_bit(int k, bit warm);
    int kk, col, cb, p, pos, nib;
    if (warm && k < WARM) return 0;
    kk  = warm ? k - WARM : k;
    col = (kk / CW) % (IMG + 1);
    cb  = kk % CW;
    p   = cb / PB;
    pos = PB - 1 - (cb % PB);
    nib = (col == 0) ? mark(p) : pix(col - 1, p);
    return (nib >> pos) & 1;
  endfunction

  task automatic spi_bit(output logic b);
    @(negedge clk) sck = 1'b0;
    repeat (4) @(negedge clk);
    b = miso;
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_bits(input int n, input bit warm, input string tag);
    logic b;
    for (int i = 0; i < n; i++) begin
      int e;
      e = exp_bit(sess_k, warm);
      spi_bit(b);
      check(b === 1'(e), tag, int'(b), e);
      sess_k++;
    end
  endtask

  task automatic sel_on();
    @(negedge clk) sel_n = 1'b0;
    sess_k = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk) sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic b;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(miso === 1'bz, "R1 miso hi-z", int'(miso), 0);
    check(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
    check(rd_en == 1'b0, "R1 rd_en", int'(rd_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: selected but acquisition off -> floating, clocks ignored
    sel_on();
    for (int i = 0; i < 5; i++) begin
      spi_bit(b);
      check(b === 1'bz, "R2 hi-z without acq_en", int'(b), 0);
    end
    sel_off();
    acq_en = 1'b1;
    repeat (4) @(negedge clk);
    check(miso === 1'bz, "R2 hi-z while deselected", int'(miso), 0);

    // R3-R6: warm-up, two full frames, part of a third
    sel_on();
    run_bits(WARM + 2 * FBITS + 70, 1'b1, "R3/R4/R5/R6 stream");
    check(fs_cnt == 3, "R7 frame_start count", fs_cnt, 3);
    check(fs_last == WARM + 2 * FBITS, "R11 third marker position", fs_last, WARM + 2 * FBITS);
    check(rd_cnt == 2 * IMG + 3, "R10 read count", rd_cnt, 2 * IMG + 3);

    // R8: abort mid-frame; clocks while deselected are ignored
    sel_off();
    check(miso === 1'bz, "R2 hi-z after abort", int'(miso), 0);
    for (int i = 0; i < 3; i++) begin
      spi_bit(b);
      check(b === 1'bz, "R2 clocks while deselected", int'(b), 0);
    end
    fs_cnt = 0;
    rd_cnt = 0;
    sel_on();
    run_bits(FBITS + CW, 1'b0, "R8 restart at marker");
    check(fs_cnt == 2, "R7 frame_start count after restart", fs_cnt, 2);
    check(fs_last == FBITS, "R6 back-to-back frame", fs_last, FBITS);

    // R9: leaving acquisition mode re-arms warm-up
    sel_off();
    acq_en = 1'b0;
    repeat (4) @(negedge clk);
    acq_en = 1'b1;
    repeat (4) @(negedge clk);
    fs_cnt = 0;
    rd_cnt = 0;
    sel_on();
    run_bits(WARM + 2 * CW, 1'b1, "R9 warm-up again");
    check(fs_cnt == 1 && fs_last == WARM, "R9 marker after warm-up", fs_last, WARM);
    sel_off();
    check(miso === 1'bz, "R2 final hi-z", int'(miso), 0);
    summary();
  end
endmodule